// File: doc/BRIEF.md
# Transmit Stream Scrambler and Three-Level Line Encoder

This block is the serial back end of a 100 Mb/s twisted-pair transmitter. On each 125 MHz clock it takes one NRZ bit. It combines that bit by XOR with one bit of a key stream, and it turns the result into a three-level line symbol. The key stream comes from an 11-stage linear feedback register. Its taps give a maximal sequence that repeats every 2047 bits. This spreads the energy of repetitive code-group patterns across the spectrum.

The line encoder moves the output level through a four-phase sequence each time it sees a scrambled one. A scrambled zero leaves the level where it is. This cuts the highest fundamental frequency on the wire in half. The scrambled NRZ bit is also driven out, so a tester can compare it against a reference. A synchronous reset loads a seed into the register. A low valid input freezes the register and both outputs.

Top module: `tx_scrambler_mlt3`

## Requirements
- R1: While `rst` is high, the block loads the key register at each clock. On the first cycle after `rst` falls, `scr_o` is 0 and `mlt3_o` is 2'b00 (level zero).
- R2: The seed maps bit i of `seed_i` to key bit X[-1-i]. So on the first valid cycle the key bit is `seed_i[10] ^ seed_i[8]`.
- R3: If `seed_i` is all zero at reset, the key register is loaded with all ones instead. The register never holds the all-zero state.
- R4: Each new key bit obeys X[n] = X[n-11] XOR X[n-9].
- R5: One clock after a cycle with `bit_valid_i` high, `scr_o` equals that cycle's `nrz_i` XOR that cycle's key bit.
- R6: The key stream has a period of exactly 2047 bits. No shift from 1 to 2046 repeats the first 11-bit window.
- R7: One clock after a valid cycle whose scrambled bit is 1, `mlt3_o` takes the next level in the order 0, +1, 0, -1, 0. After a scrambled 0 it keeps its level. The levels are encoded 0 = 2'b00, +1 = 2'b01 and -1 = 2'b11. The code 2'b10 never appears.
- R8: On a cycle with `bit_valid_i` low, the key stream does not advance and `scr_o` and `mlt3_o` keep their values. After the gap, the stream carries on as if the gap had not been there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst | input | 1 | Synchronous reset, active high; loads the seed |
| seed_i | input | 11 | Key register seed, sampled while `rst` is high |
| bit_valid_i | input | 1 | High on cycles that carry a bit |
| nrz_i | input | 1 | Plain NRZ bit |
| scr_o | output | 1 | Registered scrambled NRZ bit |
| mlt3_o | output | 2 | Registered line level: 00 = 0, 01 = +1, 11 = -1 |

## Verification
Both outputs are registered once. A bit presented with `bit_valid_i` high on one rising edge therefore shows up on `scr_o` and `mlt3_o` exactly one clock later. The same edge advances the key register. The bench changes its inputs on the falling edge and samples the outputs on the next falling edge, half a period after the edge that updates them. Its reference model therefore steps once for every valid bit and never for a gap cycle. The period check records 2058 consecutive key bits through `scr_o` with `nrz_i` held at zero. It then compares the 11-bit windows at each shift.

// File: rtl/tx_scr_pkg.sv
package tx_scr_pkg;

  typedef enum logic [1:0] {
    PH_ZERO_RISE = 2'd0,
    PH_POS       = 2'd1,
    PH_ZERO_FALL = 2'd2,
    PH_NEG       = 2'd3
  } mlt3_phase_t;

  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  // Advance the four-phase sequence on a one, hold on a zero.
  function automatic mlt3_phase_t mlt3_phase_next(input mlt3_phase_t ph, input logic one);
    mlt3_phase_t nxt;
    nxt = ph;
    if (one) nxt = mlt3_phase_t'(ph + 2'd1);
    return nxt;
  endfunction

  // Map a phase onto the two-bit signed line level.
  function automatic logic [1:0] mlt3_level(input mlt3_phase_t ph);
    logic [1:0] lvl;
    case (ph)
      PH_POS:  lvl = LVL_POS;
      PH_NEG:  lvl = LVL_NEG;
      default: lvl = LVL_ZERO;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/tx_keystream_gen.sv
module tx_keystream_gen #(
  parameter int unsigned        LFSR_LEN      = 11,
  parameter int unsigned        TAP_POS       = 9,
  parameter logic [LFSR_LEN-1:0] FALLBACK_SEED = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LFSR_LEN-1:0] seed_i,
  input  logic                step_i,
  output logic                key_o
);

  // state_q[k] holds X[n-1-k]; the newest bit sits at index 0.
  logic [LFSR_LEN-1:0] state_q;
  logic                key_bit;
  logic                seed_is_zero;

  function automatic logic lfsr_feedback(input logic [LFSR_LEN-1:0] s);
    return s[LFSR_LEN-1] ^ s[TAP_POS-1];
  endfunction

  function automatic logic [LFSR_LEN-1:0] lfsr_shift(input logic [LFSR_LEN-1:0] s,
                                                     input logic fb);
    return {s[LFSR_LEN-2:0], fb};
  endfunction

  assign seed_is_zero = (seed_i == '0);
  assign key_bit      = lfsr_feedback(state_q);
  assign key_o        = key_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= seed_is_zero ? FALLBACK_SEED : seed_i;
    end else if (step_i) begin
      state_q <= lfsr_shift(state_q, key_bit);
    end
  end

  // R3: the all-zero lock-up state is never reached
  a_r3_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

  // R2, R3: the seed, or the fallback for a zero seed, is in place after reset
  a_r3_seed_loaded: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (state_q != '0) &&
                   (($past(seed_i) == '0) || (state_q == $past(seed_i))));

  // R8: no advance without a step
  a_r8_state_hold: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(state_q));

  // R4: the newest bit after a step is the key bit that was offered
  a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
    step_i |=> state_q[0] == $past(key_o));

endmodule

// File: rtl/tx_mlt3_encoder.sv
module tx_mlt3_encoder
  import tx_scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_i,
  input  logic       bit_i,
  output logic [1:0] level_o
);

  mlt3_phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ZERO_RISE;
    end else if (step_i) begin
      phase_q <= mlt3_phase_next(phase_q, bit_i);
    end
  end

  assign level_o = mlt3_level(phase_q);

  // R7: the unused code never appears
  a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
    level_o != 2'b10);

  // R7: every level change passes through zero
  a_r7_via_zero: assert property (@(posedge clk) disable iff (rst)
    (level_o != $past(level_o)) |-> (level_o == LVL_ZERO || $past(level_o) == LVL_ZERO));

  // R7: after +1 the next move goes to zero and then to -1
  a_r7_order_after_pos: assert property (@(posedge clk) disable iff (rst)
    ($past(phase_q) == PH_ZERO_FALL && phase_q != PH_ZERO_FALL) |-> level_o == LVL_NEG);

  // R8: the level holds without a step
  a_r8_level_hold: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(level_o));

endmodule

// File: rtl/tx_scrambler_mlt3.sv
module tx_scrambler_mlt3
  import tx_scr_pkg::*;
#(
  parameter int unsigned LFSR_LEN = 11,
  parameter int unsigned TAP_POS  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LFSR_LEN-1:0] seed_i,
  input  logic                bit_valid_i,
  input  logic                nrz_i,
  output logic                scr_o,
  output logic [1:0]          mlt3_o
);

  localparam logic [LFSR_LEN-1:0] FALLBACK = '1;

  logic key_bit;
  logic scr_bit;
  logic scr_q;

  tx_keystream_gen #(
    .LFSR_LEN      (LFSR_LEN),
    .TAP_POS       (TAP_POS),
    .FALLBACK_SEED (FALLBACK)
  ) u_key (
    .clk    (clk),
    .rst    (rst),
    .seed_i (seed_i),
    .step_i (bit_valid_i),
    .key_o  (key_bit)
  );

  assign scr_bit = nrz_i ^ key_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      scr_q <= 1'b0;
    end else if (bit_valid_i) begin
      scr_q <= scr_bit;
    end
  end

  assign scr_o = scr_q;

  tx_mlt3_encoder u_mlt3 (
    .clk     (clk),
    .rst     (rst),
    .step_i  (bit_valid_i),
    .bit_i   (scr_bit),
    .level_o (mlt3_o)
  );

  // R1: clean outputs on the first cycle out of reset
  a_r1_reset_outputs: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (scr_o == 1'b0) && (mlt3_o == LVL_ZERO));

  // R7: a scrambled zero leaves the line level alone
  a_r7_zero_holds: assert property (@(posedge clk) disable iff (rst)
    (bit_valid_i && !scr_bit) |=> $stable(mlt3_o));

  // R7: a scrambled one always moves the line level
  a_r7_one_moves: assert property (@(posedge clk) disable iff (rst)
    (bit_valid_i && scr_bit) |=> !$stable(mlt3_o));

  // R5: the registered bit reflects the valid cycle's scramble result
  a_r5_scr_registered: assert property (@(posedge clk) disable iff (rst)
    bit_valid_i |=> scr_o == $past(scr_bit));

  // R8: the scrambled output holds through gaps
  a_r8_scr_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_valid_i |=> $stable(scr_o));

endmodule

// File: tb/tx_scrambler_mlt3_bench.sv
module tx_scrambler_mlt3_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] seed = 11'h001;
  logic        valid = 1'b0;
  logic        nrz = 1'b0;
  wire         scr;
  wire  [1:0]  mlt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  tx_scrambler_mlt3 u_tx_scrambler_mlt3 (
    .clk         (clk),
    .rst         (rst),
    .seed_i      (seed),
    .bit_valid_i (valid),
    .nrz_i       (nrz),
    .scr_o       (scr),
    .mlt3_o      (mlt)
  );

  // Reference model: hist[k] = X[n-k], k = 1..11
  logic hist [1:11];
  int   lvl;
  int   last_dir;
  logic exp_scr;
  logic obs [0:2057];

  function automatic logic [1:0] enc(input int l);
    if (l > 0) return 2'b01;
    if (l < 0) return 2'b11;
    return 2'b00;
  endfunction

  task automatic model_load(input logic [10:0] s);
    logic [10:0] eff;
    eff = (s == 11'd0) ? 11'h7FF : s;
    for (int k = 1; k <= 11; k++) hist[k] = eff[k-1];
    lvl = 0;
    last_dir = -1;
    exp_scr = 1'b0;
  endtask

  task automatic model_step(input logic d);
    logic kb;
    kb = hist[11] ^ hist[9];
    for (int k = 11; k >= 2; k--) hist[k] = hist[k-1];
    hist[1] = kb;
    exp_scr = d ^ kb;
    if (exp_scr) begin
      if (lvl != 0) lvl = 0;
      else begin
        lvl = -last_dir;
        last_dir = lvl;
      end
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Assumes time is just after a falling edge.
  task automatic do_reset(input logic [10:0] s);
    rst = 1'b1; seed = s; valid = 1'b0; nrz = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    seed = 11'h000;
    model_load(s);
  endtask

  task automatic step(input logic v, input logic d, input string req);
    valid = v; nrz = d;
    if (v) model_step(d);
    @(posedge clk); @(negedge clk);
    check(req, "scr_o", {1'b0, scr}, {1'b0, exp_scr});
    check(req, "mlt3_o", mlt, enc(lvl));
  endtask

  task automatic t_reset();
    do_reset(11'h2C5);
    @(posedge clk); @(negedge clk);
    check("R1", "scr_o after reset", {1'b0, scr}, 2'b00);
    check("R1", "mlt3_o after reset", mlt, 2'b00);
  endtask

  task automatic t_seed_map();
    // R2: seed bit 10 = 1, bit 8 = 0 -> first key bit 1
    do_reset(11'b100_0000_0000);
    step(1'b1, 1'b0, "R2");
    check("R2", "first key bit", {1'b0, scr}, 2'b01);
    do_reset(11'b101_0000_0000);
    step(1'b1, 1'b0, "R2");
    check("R2", "first key bit", {1'b0, scr}, 2'b00);
  endtask

  task automatic t_zero_seed();
    do_reset(11'h000);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R3");
    // R3: fallback all ones gives key 0 first (1^1)
  endtask

  task automatic t_recurrence();
    do_reset(11'h4A5);
    for (int i = 0; i < 80; i++) step(1'b1, 1'b0, "R4");
  endtask

  task automatic t_scramble();
    do_reset(11'h13B);
    for (int i = 0; i < 120; i++) step(1'b1, logic'((i * 7 + i / 3) % 2), "R5");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, "R5");
  endtask

  task automatic t_mlt3();
    // R7: ones-heavy and zeros-heavy data both drive the level sequence
    do_reset(11'h7FF);
    for (int i = 0; i < 60; i++) step(1'b1, hist[11] ^ hist[9], "R7"); // scrambled 0s
    for (int i = 0; i < 60; i++) step(1'b1, ~(hist[11] ^ hist[9]), "R7"); // scrambled 1s
    for (int i = 0; i < 60; i++) step(1'b1, logic'(i % 3 == 0), "R7");
  endtask

  task automatic t_gaps();
    do_reset(11'h0F1);
    for (int i = 0; i < 90; i++) begin
      if (i % 4 == 1 || i % 7 == 0) step(1'b0, logic'(i % 2), "R8");
      else step(1'b1, logic'((i / 2) % 2), "R8");
    end
  endtask

  task automatic t_period();
    bit same;
    bit early;
    do_reset(11'h35A);
    for (int i = 0; i < 2058; i++) begin
      step(1'b1, 1'b0, "R6");
      obs[i] = scr;
    end
    same = 1'b1;
    for (int i = 0; i < 11; i++) if (obs[i] !== obs[i + 2047]) same = 1'b0;
    check("R6", "repeat at 2047", {1'b0, same}, 2'b01);
    early = 1'b0;
    for (int p = 1; p < 2047; p++) begin
      bit eq;
      eq = 1'b1;
      for (int i = 0; i < 11; i++) if (obs[i] !== obs[i + p]) eq = 1'b0;
      if (eq) early = 1'b1;
    end
    check("R6", "no earlier repeat", {1'b0, early}, 2'b00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_seed_map();
    t_zero_seed();
    t_recurrence();
    t_scramble();
    t_mlt3();
    t_gaps();
    t_period();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule